// File: doc/BRIEF.md
# Bidirectional GPIO Port with Peripheral Pin Takeover

This block is one 8-bit general-purpose I/O port. Each pin can either drive a value held in an output latch or stay released so that an outside source sets its level. A direction register picks, bit by bit, which pins drive. Software reaches the latch and the direction register through a small register interface with two byte addresses. Writes take effect on the clock edge. Reads are combinational.

An on-chip peripheral can claim any pin by raising that pin's peripheral enable. While the enable is high, the pin drives the peripheral's value no matter what the direction bit holds. Pin levels are not read directly. They pass through a two-flop synchroniser, and the synchronised level is what a read of the data address returns. The same level is also forwarded to peripherals that use pins as inputs. Software is expected to release a pin (direction bit 0) before a peripheral uses it as an input. The block does not enforce this.

The pad itself is outside the block. The block drives a per-pin drive-enable and a per-pin drive value, and it receives the level seen at each pad.

Top module: `gpio_port_ovr`

## Requirements
- R1: While reset is asserted and after it is released, the direction register reads 0x00, and no pin is driven unless its peripheral enable is high.
- R2: A pin whose direction bit is 1 and whose peripheral enable is 0 has `pad_oe` = 1, and `pad_out` equals that bit of the output latch.
- R3: A pin whose direction bit is 0 and whose peripheral enable is 0 has `pad_oe` = 0.
- R4: A pin whose peripheral enable is 1 has `pad_oe` = 1, and `pad_out` equals that pin's `perip_out` bit, whatever its direction bit holds.
- R5: A read at address 0x02 returns the synchronised pad level. Bit i is 1 for high and 0 for low. A level present at `pad_in` on a clock edge appears in `bus_rdata` after the following edge, which is two edges in total.
- R6: A read at address 0x12 returns the stored direction register. A bit value of 1 means output.
- R7: A write to address 0x02 with `bus_we` high loads `bus_wdata` into the output latch on that clock edge. The latch changes only through such a write.
- R8: A read at any address other than 0x02 or 0x12 returns 0x00. A write to such an address changes neither the latch nor the direction register.
- R9: `perip_in` always equals the synchronised pad level that a read at 0x02 would return.
- R10: A write to address 0x12 with `bus_we` high loads `bus_wdata` into the direction register on that clock edge. The new direction shows at `pad_oe` right after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| bus_addr | input | 8 | Register byte address |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for `bus_addr` |
| perip_oe | input | 8 | Per-pin peripheral takeover enable |
| perip_out | input | 8 | Per-pin peripheral drive value |
| perip_in | output | 8 | Synchronised pad level forwarded to peripherals |
| pad_in | input | 8 | Level observed at each pad |
| pad_out | output | 8 | Value to drive on each pad |
| pad_oe | output | 8 | Per-pad driver enable (1 = drive) |

## Verification
Two things can happen in the same cycle: a register write that changes the direction or the latch, and a change of a peripheral's enable for the same pins. Either one can alter what a pin drives, and through the pad loopback it also alters what is later read back. The bench provokes this collision on purpose. In one cycle it writes the direction register and flips the peripheral enables over overlapping bits, and it then keeps mixing the two in pseudo-random traffic. A behavioural model in the bench predicts `pad_oe`, `pad_out`, `perip_in` and `bus_rdata` every cycle. The takeover must win in the cycle it is asserted, and the newly written direction must govern from the next edge for pins that are not claimed.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int unsigned PORT_W  = 8;
  localparam int unsigned ADDR_W  = 8;

  typedef logic [PORT_W-1:0] port_t;

  // Driver enable: a pin drives when software selects output or a peripheral claims it.
  function automatic port_t drive_enable(input port_t dir, input port_t poe);
    return dir | poe;
  endfunction

  // Drive value: the peripheral value wins on claimed pins, the latch elsewhere.
  function automatic port_t drive_value(input port_t latch, input port_t poe, input port_t pval);
    return (poe & pval) | (~poe & latch);
  endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) stage_q[s] <= '0;
          else        stage_q[s] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) stage_q[s] <= '0;
          else        stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs #(
  parameter int unsigned        WIDTH     = 8,
  parameter int unsigned        ADDR_W    = 8,
  parameter logic [ADDR_W-1:0]  DATA_ADDR = 8'h02,
  parameter logic [ADDR_W-1:0]  DIR_ADDR  = 8'h12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [WIDTH-1:0]  bus_wdata,
  input  logic [WIDTH-1:0]  pin_level,
  output logic [WIDTH-1:0]  bus_rdata,
  output logic [WIDTH-1:0]  dir_q,
  output logic [WIDTH-1:0]  latch_q,
  output logic              wr_latch,
  output logic              wr_dir,
  output logic              addr_unmapped
);
  logic sel_data;
  logic sel_dir;

  assign sel_data      = (bus_addr == DATA_ADDR);
  assign sel_dir       = (bus_addr == DIR_ADDR);
  assign addr_unmapped = !sel_data && !sel_dir;
  assign wr_latch      = bus_we && sel_data;
  assign wr_dir        = bus_we && sel_dir;

  // Direction register: all inputs out of reset.
  always_ff @(posedge clk) begin
    if (!rst_n)      dir_q <= '0;
    else if (wr_dir) dir_q <= bus_wdata;
  end

  // Output latch: no reset value is defined.
  always_ff @(posedge clk) begin
    if (wr_latch) latch_q <= bus_wdata;
  end

  always_comb begin
    bus_rdata = '0;
    if (sel_data)     bus_rdata = pin_level;
    else if (sel_dir) bus_rdata = dir_q;
  end
endmodule

// File: rtl/gpio_pad_mux.sv
module gpio_pad_mux #(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] dir_q,
  input  logic [WIDTH-1:0] latch_q,
  input  logic [WIDTH-1:0] perip_oe,
  input  logic [WIDTH-1:0] perip_out,
  output logic [WIDTH-1:0] pad_out,
  output logic [WIDTH-1:0] pad_oe
);
  import gpio_pkg::*;

  generate
    for (genvar i = 0; i < WIDTH; i++) begin : g_pin
      port_t en_vec;
      port_t val_vec;
      assign en_vec  = drive_enable(port_t'(dir_q), port_t'(perip_oe));
      assign val_vec = drive_value(port_t'(latch_q), port_t'(perip_oe), port_t'(perip_out));
      assign pad_oe[i]  = en_vec[i];
      assign pad_out[i] = val_vec[i];
    end
  endgenerate
endmodule

// File: rtl/gpio_port_ovr.sv
module gpio_port_ovr #(
  parameter int unsigned                    WIDTH       = gpio_pkg::PORT_W,
  parameter int unsigned                    ADDR_W      = gpio_pkg::ADDR_W,
  parameter logic [gpio_pkg::ADDR_W-1:0]    DATA_ADDR   = 8'h02,
  parameter logic [gpio_pkg::ADDR_W-1:0]    DIR_ADDR    = 8'h12,
  parameter int unsigned                    SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [WIDTH-1:0]  bus_wdata,
  output logic [WIDTH-1:0]  bus_rdata,
  input  logic [WIDTH-1:0]  perip_oe,
  input  logic [WIDTH-1:0]  perip_out,
  output logic [WIDTH-1:0]  perip_in,
  input  logic [WIDTH-1:0]  pad_in,
  output logic [WIDTH-1:0]  pad_out,
  output logic [WIDTH-1:0]  pad_oe
);
  // Named internal events, visible to the bound checker.
  logic [WIDTH-1:0] pin_sync;
  logic [WIDTH-1:0] dir_q;
  logic [WIDTH-1:0] latch_q;
  logic             wr_latch;
  logic             wr_dir;
  logic             addr_unmapped;

  gpio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (pad_in),
    .sync_out (pin_sync)
  );

  gpio_regs #(
    .WIDTH(WIDTH), .ADDR_W(ADDR_W), .DATA_ADDR(DATA_ADDR), .DIR_ADDR(DIR_ADDR)
  ) u_regs (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_addr      (bus_addr),
    .bus_we        (bus_we),
    .bus_wdata     (bus_wdata),
    .pin_level     (pin_sync),
    .bus_rdata     (bus_rdata),
    .dir_q         (dir_q),
    .latch_q       (latch_q),
    .wr_latch      (wr_latch),
    .wr_dir        (wr_dir),
    .addr_unmapped (addr_unmapped)
  );

  gpio_pad_mux #(.WIDTH(WIDTH)) u_mux (
    .dir_q     (dir_q),
    .latch_q   (latch_q),
    .perip_oe  (perip_oe),
    .perip_out (perip_out),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe)
  );

  assign perip_in = pin_sync;
endmodule

// File: rtl/gpio_port_ovr_chk.sv
module gpio_port_ovr_chk #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned ADDR_W = 8,
  parameter logic [ADDR_W-1:0] DATA_ADDR = 8'h02,
  parameter logic [ADDR_W-1:0] DIR_ADDR  = 8'h12
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic [WIDTH-1:0]  bus_wdata,
  input logic [WIDTH-1:0]  bus_rdata,
  input logic [WIDTH-1:0]  perip_oe,
  input logic [WIDTH-1:0]  perip_out,
  input logic [WIDTH-1:0]  perip_in,
  input logic [WIDTH-1:0]  pad_in,
  input logic [WIDTH-1:0]  pad_out,
  input logic [WIDTH-1:0]  pad_oe,
  input logic [WIDTH-1:0]  dir_q,
  input logic [WIDTH-1:0]  latch_q,
  input logic              addr_unmapped
);
  // Edges seen since reset release, saturating at two.
  logic [1:0] live_cnt;
  always_ff @(posedge clk) begin
    if (!rst_n)              live_cnt <= '0;
    else if (live_cnt != 2'd2) live_cnt <= live_cnt + 2'd1;
  end

  p_reset_dir_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (dir_q == '0));

  p_released_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_oe & ~dir_q & ~perip_oe) == '0));

  p_output_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_out & dir_q & ~perip_oe) == (latch_q & dir_q & ~perip_oe)));

  p_takeover_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (((pad_oe & perip_oe) == perip_oe) && ((pad_out & perip_oe) == (perip_out & perip_oe))));

  p_sync_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (live_cnt == 2'd2) |-> (perip_in == $past(pad_in, 2)));

  p_read_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == DATA_ADDR) |-> (bus_rdata == perip_in));

  p_read_dir_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == DIR_ADDR) |-> (bus_rdata == dir_q));

  p_latch_wr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == DATA_ADDR) |=> (latch_q == $past(bus_wdata)));

  p_dir_wr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == DIR_ADDR) |=> (dir_q == $past(bus_wdata)));

  p_unmapped_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && addr_unmapped) |=> ($stable(dir_q) && $stable(latch_q)));

  p_unmapped_rd_r8: assert property (@(posedge clk) disable iff (!rst_n)
    addr_unmapped |-> (bus_rdata == '0));
endmodule

bind gpio_port_ovr gpio_port_ovr_chk #(
  .WIDTH(WIDTH), .ADDR_W(ADDR_W), .DATA_ADDR(DATA_ADDR), .DIR_ADDR(DIR_ADDR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .perip_oe(perip_oe),
  .perip_out(perip_out), .perip_in(perip_in), .pad_in(pad_in),
  .pad_out(pad_out), .pad_oe(pad_oe), .dir_q(dir_q), .latch_q(latch_q),
  .addr_unmapped(addr_unmapped)
);

// File: tb/gpio_port_ovr_bench.sv
`timescale 1ns/1ps
module gpio_port_ovr_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] bus_addr = 8'h00;
  logic       bus_we = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic [7:0] perip_oe = 8'h00;
  logic [7:0] perip_out = 8'h00;
  logic [7:0] perip_in;
  logic [7:0] pad_in;
  logic [7:0] pad_out;
  logic [7:0] pad_oe;
  logic [7:0] ext_lvl = 8'h00;   // what the outside world drives on released pads

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  // Pad loopback: a driven pad shows its driven value, a released one the outside level.
  assign pad_in = (pad_oe & pad_out) | (~pad_oe & ext_lvl);

  gpio_port_ovr u_gpio_port_ovr (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .perip_oe(perip_oe),
    .perip_out(perip_out), .perip_in(perip_in), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe)
  );

  // Behavioural reference: register state plus a queue of sampled pad levels.
  logic [7:0] m_dir = 8'h00;
  logic [7:0] m_lat = 8'h00;
  logic [7:0] m_hist[$];

  function automatic logic [7:0] m_oe();
    return m_dir | perip_oe;
  endfunction
  function automatic logic [7:0] m_val();
    logic [7:0] v;
    for (int i = 0; i < 8; i++) v[i] = perip_oe[i] ? perip_out[i] : m_lat[i];
    return v;
  endfunction
  function automatic logic [7:0] m_pad();
    logic [7:0] v;
    for (int i = 0; i < 8; i++) v[i] = m_oe() ? 1'b0 : 1'b0;
    for (int i = 0; i < 8; i++) v[i] = m_oe()[i] ? m_val()[i] : ext_lvl[i];
    return v;
  endfunction
  function automatic logic [7:0] m_sync();
    return (m_hist.size() >= 2) ? m_hist[m_hist.size()-2] : 8'h00;
  endfunction
  function automatic logic [7:0] m_rd();
    if (bus_addr == 8'h02) return m_sync();
    if (bus_addr == 8'h12) return m_dir;
    return 8'h00;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_dir = 8'h00;
      m_hist.delete();
      m_hist.push_back(8'h00);
      m_hist.push_back(8'h00);
    end else begin
      m_hist.push_back(m_pad());
      if (m_hist.size() > 4) void'(m_hist.pop_front());
      if (bus_we && bus_addr == 8'h02) m_lat = bus_wdata;
      if (bus_we && bus_addr == 8'h12) m_dir = bus_wdata;
    end
  end

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h at %0t", tag, act, exp, $time);
    end
  endtask

  // Full per-cycle comparison against the model; pad_out only on driven bits.
  task automatic compare_all();
    check("R2 R3 R4 pad_oe", pad_oe, m_oe());
    check("R2 R4 pad_out", pad_out & m_oe(), m_val() & m_oe());
    check("R9 perip_in", perip_in, m_sync());
    check("R5 R6 R8 bus_rdata", bus_rdata, m_rd());
  endtask

  task automatic step(input logic [7:0] a, input logic we, input logic [7:0] wd,
                      input logic [7:0] poe, input logic [7:0] pout, input logic [7:0] ext);
    @(negedge clk);
    bus_addr = a; bus_we = we; bus_wdata = wd;
    perip_oe = poe; perip_out = pout; ext_lvl = ext;
    #1;
    if (rst_n) compare_all();
  endtask

  task automatic idle(input logic [7:0] a, input int n);
    for (int k = 0; k < n; k++) step(a, 1'b0, 8'h00, perip_oe, perip_out, ext_lvl);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    // R1: reset state, checked while reset is held.
    repeat (3) @(negedge clk);
    bus_addr = 8'h12; #1;
    check("R1 dir during reset", bus_rdata, 8'h00);
    check("R1 pad_oe during reset", pad_oe, 8'h00);
    @(negedge clk); rst_n = 1'b1; #1;
    check("R1 dir after release", bus_rdata, 8'h00);

    // R7: load latch; pins still released (R3).
    step(8'h02, 1'b1, 8'hA5, 8'h00, 8'h00, 8'h3C);
    step(8'h12, 1'b0, 8'h00, 8'h00, 8'h00, 8'h3C);
    check("R3 no drive with dir=0", pad_oe, 8'h00);
    // R10: direction write, visible right after the edge.
    step(8'h12, 1'b1, 8'h0F, 8'h00, 8'h00, 8'h3C);
    step(8'h12, 1'b0, 8'h00, 8'h00, 8'h00, 8'h3C);
    check("R10 pad_oe after dir write", pad_oe, 8'h0F);
    check("R6 dir readback", bus_rdata, 8'h0F);
    check("R2 pad_out low nibble", pad_out & 8'h0F, 8'h05);
    // R5: data read reflects driven low nibble and outside high nibble after sync.
    idle(8'h02, 3);
    check("R5 live level read", bus_rdata, 8'h35);

    // R5 latency: outside level change seen only after two edges.
    step(8'h02, 1'b0, 8'h00, 8'h00, 8'h00, 8'hC0);
    check("R5 before any edge", bus_rdata, 8'h35);
    step(8'h02, 1'b0, 8'h00, 8'h00, 8'h00, 8'hC0);
    check("R5 after one edge", bus_rdata, 8'h35);
    step(8'h02, 1'b0, 8'h00, 8'h00, 8'h00, 8'hC0);
    check("R5 after two edges", bus_rdata, 8'hC5);
    check("R9 perip_in matches", perip_in, 8'hC5);

    // R4: takeover of an output pin and an input pin.
    step(8'h02, 1'b0, 8'h00, 8'h81, 8'h80, 8'hC0);
    check("R4 takeover enable", pad_oe, 8'h8F);
    check("R4 takeover value", pad_out & 8'h81, 8'h80);

    // Collision: direction write and takeover change in the same cycle.
    step(8'h12, 1'b1, 8'hF0, 8'h18, 8'h08, 8'h00);
    check("R4 claim wins same cycle", pad_oe, 8'h1F);
    step(8'h12, 1'b0, 8'h00, 8'h00, 8'h00, 8'h00);
    check("R10 new dir after collision", pad_oe, 8'hF0);
    check("R2 latch drives high nibble", pad_out & 8'hF0, 8'hA0);

    // R8: unmapped writes and reads.
    step(8'h03, 1'b1, 8'h5A, 8'h00, 8'h00, 8'h00);
    check("R8 unmapped read", bus_rdata, 8'h00);
    step(8'h13, 1'b1, 8'hFF, 8'h00, 8'h00, 8'h00);
    step(8'hFF, 1'b1, 8'h00, 8'h00, 8'h00, 8'h00);
    step(8'h12, 1'b0, 8'h00, 8'h00, 8'h00, 8'h00);
    check("R8 dir untouched", bus_rdata, 8'hF0);
    step(8'h12, 1'b1, 8'hFF, 8'h00, 8'h00, 8'h00);
    step(8'h12, 1'b0, 8'h00, 8'h00, 8'h00, 8'h00);
    check("R8 latch untouched", pad_out, 8'hA5);
    // R7: latch holds without a write strobe.
    step(8'h02, 1'b0, 8'h3C, 8'h00, 8'h00, 8'h00);
    step(8'h02, 1'b0, 8'h00, 8'h00, 8'h00, 8'h00);
    check("R7 no write without strobe", pad_out, 8'hA5);

    // Mixed traffic with colliding writes and takeovers.
    lfsr = 16'hACE1;
    for (int n = 0; n < 400; n++) begin
      logic [7:0] a;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      case (lfsr[1:0])
        2'd0: a = 8'h02;
        2'd1: a = 8'h12;
        2'd2: a = lfsr[9:2];
        default: a = 8'h02;
      endcase
      step(a, lfsr[3] & lfsr[7], lfsr[15:8], lfsr[11:4] & lfsr[14:7], lfsr[12:5], lfsr[7:0] ^ lfsr[15:8]);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule